// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block supplies the low-order address bits for a four-beat memory burst. An address strobe loads a starting offset, and from then on each clock edge that sees the step control held low moves the burst on by one beat. The sequencer is shared by read and write bursts. It has no notion of direction, and it touches neither the data path nor the upper address bits.

Two beat orders are offered. In XOR order the address is the starting offset XOR the beat count. In linear order it is the starting offset plus the beat count, modulo the burst length. The order select pin is captured with the start offset, so the order chosen at load time holds for the whole burst. A burst can start at any of the four offsets. Once the last beat has been issued, the next step wraps back to the starting offset.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status signal that is sampled on the rising clock edge.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `addr_o` is 0 and `beat_o` is 0.
- R2: When `seed_i` is high at a rising edge, `addr_o` equals the sampled `seed_addr_i` and `beat_o` equals 0 after that edge.
- R3: When `seed_i` is low and `step_n_i` is low at a rising edge, `beat_o` increments by one, modulo 4, after that edge.
- R4: When `seed_i` is low and `step_n_i` is high at a rising edge, `addr_o` and `beat_o` keep their values.
- R5: If `order_sel_i` was 1 at the load, then `addr_o` = start XOR `beat_o`.
- R6: If `order_sel_i` was 0 at the load, then `addr_o` = (start + `beat_o`) mod 4.
- R7: When `seed_i` is high, it takes priority over a low `step_n_i`: the burst reloads and the beat count does not advance.
- R8: A step taken from beat 3 returns `beat_o` to 0 and `addr_o` to the start offset.
- R9: `order_sel_i` is sampled only at a load. Changing it in the middle of a burst has no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_i | input | 1 | Address strobe that loads a new start offset |
| seed_addr_i | input | 2 | Start offset captured when `seed_i` is high |
| order_sel_i | input | 1 | Beat order select: 1 = XOR order, 0 = linear order |
| step_n_i | input | 1 | Active-low step control that advances one beat |
| addr_o | output | 2 | Current low-order burst address |
| beat_o | output | 2 | Current beat index, 0 to 3 |

## Verification
Every result appears exactly one clock edge after the stimulus that causes it: the load, step or hold registers at that edge, and `addr_o` is a combinational map of the registered state. The bench drives its inputs on the falling edge and, in the same call, pushes the expected pair of `addr_o` and `beat_o` onto a queue. A monitor samples one time unit after the next rising edge and pops one entry per edge, so every comparison lines up with the edge that produced it.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_i,
  input  logic [W-1:0] seed_addr_i,
  input  order_e       order_i,
  input  logic         step_n_i,
  output logic [W-1:0] start_o,
  output logic [W-1:0] beat_o,
  output order_e       order_o
);
  logic [W-1:0] start_q, beat_q;
  order_e       order_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
      order_q <= ORD_XOR;
    end else if (seed_i) begin
      start_q <= seed_addr_i;
      beat_q  <= '0;
      order_q <= order_i;
    end else if (!step_n_i) begin
      beat_q  <= W'(beat_q + 1'b1);
    end
  end

  assign start_o = start_q;
  assign beat_o  = beat_q;
  assign order_o = order_q;

  // R2 / R7: a load reseeds the burst and clears the beat count
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_i |=> (beat_q == '0) && (start_q == $past(seed_addr_i)));
  assert_seed_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_i && !step_n_i) |=> beat_q == '0);
  // R3
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_i && !step_n_i) |=> beat_q == W'($past(beat_q) + 1'b1));
  // R4
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_i && step_n_i) |=> $stable(beat_q) && $stable(start_q));
  // R9
  assert_order_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_i |=> $stable(order_q));
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_seq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] beat_i,
  input  order_e       order_i,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] xor_addr;
  logic [W-1:0] lin_addr;

  for (genvar b = 0; b < W; b++) begin : g_xor_bit
    assign xor_addr[b] = start_i[b] ^ beat_i[b];
  end

  assign lin_addr = W'(start_i + beat_i);

  always_comb begin
    if (order_i == ORD_XOR) addr_o = xor_addr;
    else                    addr_o = lin_addr;
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_i,
  input  logic [ADDR_W-1:0] seed_addr_i,
  input  logic              order_sel_i,
  input  logic              step_n_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] beat_o
);
  localparam logic [ADDR_W-1:0] LAST_BEAT = '1;

  logic [ADDR_W-1:0] start_w;
  order_e            order_w;

  burst_beat_ctr #(.W(ADDR_W)) ctr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_i     (seed_i),
    .seed_addr_i(seed_addr_i),
    .order_i    (order_e'(order_sel_i)),
    .step_n_i   (step_n_i),
    .start_o    (start_w),
    .beat_o     (beat_o),
    .order_o    (order_w)
  );

  burst_addr_map #(.W(ADDR_W)) map_i (
    .start_i(start_w),
    .beat_i (beat_o),
    .order_i(order_w),
    .addr_o (addr_o)
  );

  // R8: a step taken from the last beat returns to the start offset
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_i && !step_n_i && beat_o == LAST_BEAT) |=> (beat_o == '0) && (addr_o == start_w));
  // R5: in XOR order, addr XOR beat stays constant while stepping
  assert_xor_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_i && order_w == ORD_XOR) |=> (addr_o ^ beat_o) == $past(addr_o ^ beat_o));
  // R6: in linear order, addr minus beat stays constant while stepping
  assert_lin_inv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_i && order_w == ORD_LINEAR) |=>
      ADDR_W'(addr_o - beat_o) == $past(ADDR_W'(addr_o - beat_o)));
endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seed_i = 1'b0;
  logic [1:0] seed_addr_i = '0;
  logic       order_sel_i = 1'b1;
  logic       step_n_i = 1'b1;
  logic [1:0] addr_o, beat_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] addr;
    logic [1:0] beat;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  logic [1:0] m_start = '0;
  logic [1:0] m_beat = '0;
  logic       m_xor = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .seed_addr_i(seed_addr_i),
    .order_sel_i(order_sel_i), .step_n_i(step_n_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  function automatic logic [1:0] model_addr();
    if (m_xor) return m_start ^ m_beat;
    return 2'(m_start + m_beat);
  endfunction

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic cyc(input logic ld, input logic [1:0] sa, input logic ord,
                     input logic stp_n, input string req);
    exp_t e;
    @(negedge clk);
    seed_i = ld; seed_addr_i = sa; order_sel_i = ord; step_n_i = stp_n;
    if (ld) begin
      m_start = sa; m_beat = '0; m_xor = ord;
    end else if (!stp_n) begin
      m_beat = 2'(m_beat + 1);
    end
    e.addr = model_addr(); e.beat = m_beat; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (addr_o !== e.addr || beat_o !== e.beat) begin
        bad++;
        $display("FAIL %s: addr/beat actual=%0d/%0d expected=%0d/%0d",
                 e.req, addr_o, beat_o, e.addr, e.beat);
      end
    end
  end

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (addr_o !== 2'd0 || beat_o !== 2'd0) begin
      bad++;
      $display("FAIL R1: actual=%0d/%0d expected=0/0", addr_o, beat_o);
    end
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 2'd0, 1, 1, "R1");
    // R5 / R3 / R8: XOR order from every start, four steps, then a wrap
    for (int s = 0; s < 4; s++) begin
      cyc(1, 2'(s), 1, 1, "R2");
      for (int k = 0; k < 4; k++) cyc(0, 2'(s), 1, 0, (k == 3) ? "R8" : "R5");
    end
    // R6: linear order from every start
    for (int s = 0; s < 4; s++) begin
      cyc(1, 2'(s), 0, 1, "R2");
      for (int k = 0; k < 5; k++) cyc(0, 2'(s), 0, 0, (k == 3) ? "R8" : "R6");
    end
    // R4: hold with step high, seed_addr_i wiggled
    cyc(1, 2'd2, 0, 1, "R2");
    cyc(0, 2'd2, 0, 0, "R3");
    cyc(0, 2'd1, 0, 1, "R4");
    cyc(0, 2'd3, 1, 1, "R4");
    cyc(0, 2'd0, 0, 0, "R3");
    // R7: a load with step low in the middle of a burst
    cyc(1, 2'd3, 1, 0, "R7");
    cyc(0, 2'd0, 1, 0, "R5");
    cyc(1, 2'd1, 0, 0, "R7");
    // R9: order pin flips mid-burst but has no effect
    cyc(1, 2'd3, 0, 1, "R2");
    cyc(0, 2'd0, 1, 0, "R9");
    cyc(0, 2'd0, 1, 0, "R9");
    cyc(0, 2'd0, 0, 0, "R9");
    cyc(1, 2'd1, 1, 1, "R2");
    cyc(0, 2'd0, 0, 0, "R9");
    cyc(0, 2'd0, 0, 0, "R9");
    cyc(0, 2'd0, 0, 1, "R4");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule